// File: doc/BRIEF.md
# Wake event aggregator

The block gathers several wake sources into one registered wake request toward the host power logic. The sources are a software event strobe, a module interrupt event, and modem ring-indicator inputs. The module interrupt event is the rising edge of the OR of per-device interrupt lines, each gated by its own wake-on-interrupt enable bit. A ring event is a high-to-low transition on a ring-indicator input, taken after a two-flop synchronizer.

Each source owns a sticky status bit and an enable bit, both reached through a small register port. Status bits are write-1-to-clear. A software event also sets a core-side status bit. An optional link mode lets one write-1 to that core-side bit clear both copies. This suits the case where the core services the event on its own.

Top module: `wake_evt_agg`

## Requirements
- R1: After reset, the status, enable, device enable and core registers read 0, and `wake_req_o` is 0.
- R2: A rising edge of the OR of (`dev_irq_i` AND device enables) sets status bit 7 at that clock edge. A line that stays high does not set the bit again after it is cleared.
- R3: An interrupt line whose device enable bit (register 2, bit = device index) is 0 has no effect on the status.
- R4: A falling edge on `ring_i[i]` sets status bit 1+i at the third rising clock edge after the input changes. A rising edge on `ring_i[i]` sets nothing.
- R5: A pulse on `sw_evt_i` sets host status bit 0 (register 0) and core status bit 0 (register 3).
- R6: Writing 1 to a bit of register 0 clears that status bit. Writing 0 leaves the bit unchanged.
- R7: When an event and a clear write for the same status bit fall in the same cycle, the bit stays set.
- R8: Register 3 bit 1 is the link mode. When it is 1, writing 1 to register 3 bit 0 clears both the core and the host software status. When it is 0, that write clears only the core bit.
- R9: `wake_req_o` is set one cycle after any status bit and its enable bit in register 1 are both 1. It stays high until no such pair remains.
- R10: Register 1 is read/write. Only the implemented bits keep a value (bit 0, bits 1..N_RI, bit 7); the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_evt_i | input | 1 | Software event strobe |
| dev_irq_i | input | N_DEV | Per-device interrupt lines, synchronous |
| ring_i | input | N_RI | Modem ring indicators, asynchronous, idle high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 device enable, 3 core |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register, combinational |
| wake_req_o | output | 1 | Registered wake request |

## Verification
The assertions assume that `dev_irq_i` and `sw_evt_i` are synchronous to `clk_i`. They also assume that the register port presents one address and one write strobe per cycle, with no other master. The bench drives every input half a cycle away from the sampling edge. It moves the ring inputs at the same time, since the synchronizer absorbs their phase. The randomized phase mixes events with clears on the same bits, so that the priority and link rules are reached under those same conditions.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SW_BIT  = 0;
  localparam int unsigned RI_BASE = 1;
  localparam int unsigned IRQ_BIT = 7;

  localparam logic [1:0] ADDR_STS  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_DEV  = 2'd2;
  localparam logic [1:0] ADDR_CORE = 2'd3;

  localparam int unsigned CORE_STS_BIT  = 0;
  localparam int unsigned CORE_LINK_BIT = 1;

  function automatic logic [REG_W-1:0] impl_mask(int unsigned n_ri);
    logic [REG_W-1:0] m;
    m = '0;
    m[SW_BIT]  = 1'b1;
    m[IRQ_BIT] = 1'b1;
    for (int unsigned i = 0; i < n_ri; i++) m[RI_BASE+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wake_sts_cell.sv
module wake_sts_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/wake_ri_fall.sv
module wake_ri_fall #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ring_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_ri
    logic s1_q, s2_q, prev_q;
    // idle high after reset so no false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= ring_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign fall_o[g] = prev_q & ~s2_q;
  end
endmodule

// File: rtl/wake_irq_edge.sv
module wake_irq_edge #(
  parameter int unsigned N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] irq_i,
  input  logic [N_DEV-1:0] en_i,
  output logic             rise_o
);
  logic any_irq, prev_q;

  assign any_irq = |(irq_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= any_irq;
  end

  assign rise_o = any_irq & ~prev_q;
endmodule

// File: rtl/wake_evt_agg.sv
module wake_evt_agg
  import wake_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned N_RI  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_evt_i,
  input  logic [N_DEV-1:0] dev_irq_i,
  input  logic [N_RI-1:0]  ring_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             wake_req_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(N_RI);

  logic [N_RI-1:0]  ri_fall;
  logic             irq_rise;
  logic [REG_W-1:0] set_vec, clr_vec, host_sts_q, en_q;
  logic [N_DEV-1:0] dev_en_q;
  logic             core_sts_q, link_q, wake_q;
  logic             wr_sts, wr_en, wr_dev, wr_core, core_clr;

  assign wr_sts  = reg_we_i && (reg_addr_i == ADDR_STS);
  assign wr_en   = reg_we_i && (reg_addr_i == ADDR_EN);
  assign wr_dev  = reg_we_i && (reg_addr_i == ADDR_DEV);
  assign wr_core = reg_we_i && (reg_addr_i == ADDR_CORE);
  assign core_clr = wr_core & reg_wdata_i[CORE_STS_BIT];

  wake_ri_fall #(.N(N_RI)) i_ri (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ring_i(ring_i),
    .fall_o(ri_fall)
  );

  wake_irq_edge #(.N_DEV(N_DEV)) i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (dev_irq_i),
    .en_i  (dev_en_q),
    .rise_o(irq_rise)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SW_BIT]  = sw_evt_i;
    set_vec[IRQ_BIT] = irq_rise;
    for (int unsigned i = 0; i < N_RI; i++) set_vec[RI_BASE+i] = ri_fall[i];
    clr_vec = wr_sts ? reg_wdata_i : '0;
    // linked mode: core clear also drops host copy
    if (core_clr && link_q) clr_vec[SW_BIT] = 1'b1;
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_sts
    if (IMPL[b]) begin : g_cell
      wake_sts_cell i_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_vec[b]),
        .clr_i (clr_vec[b]),
        .q_o   (host_sts_q[b])
      );
    end else begin : g_zero
      assign host_sts_q[b] = 1'b0;
    end
  end

  wake_sts_cell i_core_cell (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sw_evt_i),
    .clr_i (core_clr),
    .q_o   (core_sts_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      dev_en_q <= '0;
      link_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (wr_en)   en_q     <= reg_wdata_i & IMPL;
      if (wr_dev)  dev_en_q <= reg_wdata_i[N_DEV-1:0];
      if (wr_core) link_q   <= reg_wdata_i[CORE_LINK_BIT];
      wake_q <= |(host_sts_q & en_q);
    end
  end

  assign wake_req_o = wake_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_STS:  reg_rdata_o = host_sts_q;
      ADDR_EN:   reg_rdata_o = en_q;
      ADDR_DEV:  reg_rdata_o[N_DEV-1:0] = dev_en_q;
      ADDR_CORE: begin
        reg_rdata_o[CORE_STS_BIT]  = core_sts_q;
        reg_rdata_o[CORE_LINK_BIT] = link_q;
      end
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wake_evt_agg_chk.sv
module wake_evt_agg_chk #(
  parameter int unsigned N_RI = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sw_evt_i,
  input logic            reg_we_i,
  input logic [1:0]      reg_addr_i,
  input logic [7:0]      reg_wdata_i,
  input logic            wake_req_o,
  input logic            irq_rise,
  input logic [N_RI-1:0] ri_fall,
  input logic [7:0]      host_sts_q,
  input logic [7:0]      en_q,
  input logic            core_sts_q,
  input logic            link_q
);
  a_r2_irq_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rise |=> host_sts_q[7]);

  a_r4_ring_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_fall != '0) |=> ((host_sts_q[N_RI:1] & $past(ri_fall)) == $past(ri_fall)));

  a_r5_core_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_evt_i |=> (core_sts_q && host_sts_q[0]));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_evt_i && !irq_rise && (ri_fall == '0) &&
     !(reg_we_i && (reg_addr_i == 2'd0 || reg_addr_i == 2'd3)))
    |=> $stable(host_sts_q));

  a_r8_link_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3 && reg_wdata_i[0] && link_q && !sw_evt_i)
    |=> (!host_sts_q[0] && !core_sts_q));

  a_r9_no_src_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_sts_q & en_q) == 8'h00) |=> !wake_req_o);
endmodule

bind wake_evt_agg wake_evt_agg_chk #(.N_RI(N_RI)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_evt_i   (sw_evt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .wake_req_o (wake_req_o),
  .irq_rise   (irq_rise),
  .ri_fall    (ri_fall),
  .host_sts_q (host_sts_q),
  .en_q       (en_q),
  .core_sts_q (core_sts_q),
  .link_q     (link_q)
);

// File: tb/test_wake_evt_agg.sv
module test_wake_evt_agg;
  localparam int N_DEV = 4;
  localparam int N_RI  = 2;
  localparam time TCK  = 20ns;
  localparam logic [7:0] IMPL = 8'h87; // bit0 sw, bits1..2 ring, bit7 irq

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sw_evt_i = 1'b0;
  logic [N_DEV-1:0] dev_irq_i = '0;
  logic [N_RI-1:0]  ring_i = '1;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic wake_req_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  wake_evt_agg #(.N_DEV(N_DEV), .N_RI(N_RI)) i_wake_evt_agg (
    .clk_i(clk), .rst_ni(rst_ni), .sw_evt_i(sw_evt_i), .dev_irq_i(dev_irq_i),
    .ring_i(ring_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .wake_req_o(wake_req_o)
  );

  // behavioural reference
  logic [7:0] m_sts, m_en;
  logic [N_DEV-1:0] m_dev;
  logic m_core, m_link, m_wake, m_irq_prev;
  logic [N_RI-1:0] ri_hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sts = 0; m_en = 0; m_dev = 0; m_core = 0; m_link = 0; m_wake = 0;
      m_irq_prev = 0;
      ri_hist = {'1, '1, '1};
    end else begin
      logic [7:0] set, clr;
      logic cur_irq, cclr;
      set = 0; clr = 0;
      cur_irq = |(dev_irq_i & m_dev);
      set[7] = cur_irq && !m_irq_prev;
      m_irq_prev = cur_irq;
      set[0] = sw_evt_i;
      for (int i = 0; i < N_RI; i++)
        if (ri_hist[2][i] && !ri_hist[1][i]) set[1+i] = 1'b1;
      ri_hist.push_front(ring_i);
      void'(ri_hist.pop_back());
      if (reg_we_i && reg_addr_i == 2'd0) clr = reg_wdata_i;
      cclr = reg_we_i && reg_addr_i == 2'd3 && reg_wdata_i[0];
      if (cclr && m_link) clr[0] = 1'b1;
      m_wake = |(m_sts & m_en);
      m_sts = ((m_sts & ~clr) | set) & IMPL;
      m_core = sw_evt_i | (m_core & ~cclr);
      if (reg_we_i && reg_addr_i == 2'd3) m_link = reg_wdata_i[1];
      if (reg_we_i && reg_addr_i == 2'd1) m_en = reg_wdata_i & IMPL;
      if (reg_we_i && reg_addr_i == 2'd2) m_dev = reg_wdata_i[N_DEV-1:0];
    end
  end

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_sts;
      2'd1: return m_en;
      2'd2: return {{(8-N_DEV){1'b0}}, m_dev};
      default: return {6'b0, m_link, m_core};
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_ni && !done) begin
    check(wake_req_o == m_wake, "R9 wake", wake_req_o, m_wake);
    check(reg_rdata_o == m_read(reg_addr_i), "R6/R10 readback", reg_rdata_o, m_read(reg_addr_i));
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o == exp, req, reg_rdata_o, exp);
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc();
    // R1 reset values
    rd_chk(0, 8'h00, "R1 sts"); rd_chk(1, 8'h00, "R1 en");
    rd_chk(2, 8'h00, "R1 dev"); rd_chk(3, 8'h00, "R1 core");
    check(wake_req_o == 0, "R1 wake", wake_req_o, 0);
    // R10 enable readback
    wr(1, 8'hFF);
    rd_chk(1, 8'h87, "R10 en mask");
    // R3 disabled device ignored
    dev_irq_i = 4'b0001; cyc(3);
    rd_chk(0, 8'h00, "R3 masked irq");
    dev_irq_i = 0; cyc();
    // R2 rising edge sets bit7, no retrigger while high
    wr(2, 8'h01);
    dev_irq_i = 4'b0001; cyc();
    rd_chk(0, 8'h80, "R2 irq edge");
    cyc();
    check(wake_req_o == 1, "R9 wake set", wake_req_o, 1);
    wr(0, 8'h80); cyc(2);
    rd_chk(0, 8'h00, "R2 no retrigger");
    check(wake_req_o == 0, "R9 wake drop", wake_req_o, 0);
    dev_irq_i = 0; cyc();
    // R5, R6
    sw_evt_i = 1; cyc(); sw_evt_i = 0;
    rd_chk(0, 8'h01, "R5 host sw"); rd_chk(3, 8'h01, "R5 core sw");
    wr(0, 8'h00); rd_chk(0, 8'h01, "R6 write0");
    wr(0, 8'h01); rd_chk(0, 8'h00, "R6 w1c");
    rd_chk(3, 8'h01, "R6 core untouched");
    wr(3, 8'h01); rd_chk(3, 8'h00, "R6 core w1c");
    // R8 link on
    wr(3, 8'h02);
    sw_evt_i = 1; cyc(); sw_evt_i = 0;
    wr(3, 8'h03);
    rd_chk(3, 8'h02, "R8 link core"); rd_chk(0, 8'h00, "R8 link host");
    // R8 link off
    wr(3, 8'h00);
    sw_evt_i = 1; cyc(); sw_evt_i = 0;
    wr(3, 8'h01);
    rd_chk(3, 8'h00, "R8 nolink core"); rd_chk(0, 8'h01, "R8 nolink host");
    wr(0, 8'h01);
    // R4 ring timing
    reg_addr_i = 0;
    ring_i[1] = 0;
    cyc(); check(reg_rdata_o[2] == 0, "R4 edge1", reg_rdata_o[2], 0);
    cyc(); check(reg_rdata_o[2] == 0, "R4 edge2", reg_rdata_o[2], 0);
    cyc(); check(reg_rdata_o[2] == 1, "R4 edge3", reg_rdata_o[2], 1);
    wr(0, 8'h04);
    ring_i[1] = 1; cyc(5);
    rd_chk(0, 8'h00, "R4 rise ignored");
    // R7 event beats clear
    sw_evt_i = 1; cyc();
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h01; cyc();
    reg_we_i = 0; sw_evt_i = 0;
    rd_chk(0, 8'h01, "R7 set wins");
    wr(0, 8'h01);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      sw_evt_i  = ($urandom_range(0, 7) == 0);
      dev_irq_i = N_DEV'($urandom());
      if ($urandom_range(0, 3) == 0) ring_i = N_RI'($urandom());
      reg_we_i    = ($urandom_range(0, 2) == 0);
      reg_addr_i  = 2'($urandom());
      reg_wdata_i = 8'($urandom());
      cyc();
    end
    reg_we_i = 0; sw_evt_i = 0;
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule